// File: doc/BRIEF.md
# I2C Byte Data Register with Transmit and Receive Buffering

This block is the byte data path of an I2C controller. Software sees a single data byte: writes go toward the bus and reads return the last byte received. Inside, that byte is held in three registers: a shift register that the bit engine serialises or fills, a transmit holding buffer and a receive holding buffer. Bytes move between them on their own as the controller reports bus events. A transmit-holding-empty flag and a receive-holding-full flag follow those moves.

The bus side is driven by the rest of the controller as single-cycle strobes: a start condition was seen, a byte frame finished, the slave address matched. It also supplies two level inputs, the transmit/receive direction and master/slave operation. Bit timing, arbitration, clock generation and address comparison are outside the block. In receive mode the bit engine delivers the finished byte on `bus_rx_byte` together with the frame-done strobe.

Top module: `i2c_byte_dbuf`

## Requirements
- R1: After synchronous reset, `tx_empty`=1, `shift_busy`=0, `rx_full`=0, `rx_overrun`=0, `wr_err`=0, `shift_q`=0x00 and `cpu_rd_data`=0x00.
- R2: In transmit mode (`bus_xmit`=1), an accepted CPU write while `shift_busy`=0 loads the byte straight into the shift register one cycle later (`shift_q`=data, `shift_busy`=1) and leaves `tx_empty` at 1.
- R3: An accepted transmit write while `shift_busy`=1 goes into the transmit holding buffer and clears `tx_empty`. A later frame-done in transmit mode moves that byte into the shift register and sets `tx_empty` again.
- R4: A transmit-mode frame-done with `tx_empty`=1 frees the shift register (`shift_busy`=0, `shift_q` kept), unless a CPU write arrives in the same cycle. In that case the write goes straight into the shift register.
- R5: In receive mode (`bus_xmit`=0), nothing moves from the transmit holding buffer to the shift register. A receive frame-done loads `bus_rx_byte` into `shift_q` and clears `shift_busy`.
- R6: A receive frame-done with `rx_full`=0 loads `bus_rx_byte` into the receive holding buffer (`cpu_rd_data`) and sets `rx_full`. A CPU read with no frame-done in the same cycle clears `rx_full`.
- R7: A receive frame-done while `rx_full`=1 and no CPU read in the same cycle keeps the old `cpu_rd_data` and sets the sticky `rx_overrun`.
- R8: A start condition in master mode (`bus_master`=1) discards pending transmit data. The next cycle has `tx_empty`=1, `shift_busy`=0 and `shift_q`=0x00, and a CPU write in the same cycle is also discarded.
- R9: In slave mode, a transmit write is accepted only once an address-match strobe has been seen in an earlier cycle and `bus_xmit`=1. A start condition with no match in the same cycle forgets the match. A rejected write changes no data and sets `wr_err`.
- R10: A CPU write in receive mode is ignored (the transmit buffer, shift register and `tx_empty` are unchanged) and sets the sticky `wr_err`, which only reset clears.
- R11: A receive frame-done with `rx_full`=1 and a CPU read in the same cycle loads the new byte, keeps `rx_full`=1 and leaves `rx_overrun` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | CPU write strobe to the data byte |
| cpu_wr_data | input | 8 | CPU write data |
| cpu_rd_en | input | 1 | CPU read strobe; acknowledges the receive holding buffer |
| cpu_rd_data | output | 8 | Receive holding buffer contents |
| bus_start | input | 1 | Start condition detected (strobe) |
| bus_frame_done | input | 1 | Byte frame completed (strobe) |
| bus_addr_match | input | 1 | Own slave address matched (strobe) |
| bus_xmit | input | 1 | 1 = transmit mode, 0 = receive mode |
| bus_master | input | 1 | 1 = master operation, 0 = slave |
| bus_rx_byte | input | 8 | Byte assembled by the bit engine, valid with a receive frame-done |
| shift_q | output | 8 | Shift register contents for the bit engine |
| shift_busy | output | 1 | Shift register holds a byte awaiting or in transmission |
| tx_empty | output | 1 | Transmit holding buffer empty |
| rx_full | output | 1 | Receive holding buffer full |
| rx_overrun | output | 1 | Sticky: a received byte was dropped |
| wr_err | output | 1 | Sticky: a CPU write was refused |

## Verification
Assertions check on every cycle the flag and data moves that follow from one cycle's inputs. These are the master-start flush, the receive-mode write refusal, the full flag and read acknowledge, overrun holding the old byte, and the absence of any transmit-side move in receive mode. Only the bench scenarios show multi-cycle orderings: a byte written into the holding buffer reaching the shift register after the right frame, a write colliding with a frame-done, a slave write accepted only after a match remembered across cycles and forgotten after a start, and the random mixes of mode changes, reads and frames that a reference model tracks byte by byte.

// File: rtl/i2c_dbuf_pkg.sv
package i2c_dbuf_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        SH_HOLD,
        SH_FROM_TX,
        SH_FROM_CPU,
        SH_FROM_BUS,
        SH_RELEASE,
        SH_FLUSH
    } shift_op_e;

    typedef struct packed {
        logic start;
        logic frame_done;
        logic addr_match;
        logic xmit;
        logic master;
    } bus_ev_t;

    typedef struct packed {
        shift_op_e shift_op;
        logic      tx_wr;
        logic      tx_take;
        logic      tx_flush;
        logic      rx_load;
        logic      rx_ovr;
        logic      wr_bad;
    } ctrl_t;

    function automatic logic write_permitted(input logic xmit, input logic master,
                                             input logic matched);
        return xmit && (master || matched);
    endfunction

endpackage

// File: rtl/i2c_dbuf_ctrl.sv
module i2c_dbuf_ctrl
    import i2c_dbuf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  logic    cpu_wr,
    input  logic    cpu_rd,
    input  logic    tx_empty,
    input  logic    shift_busy,
    input  logic    rx_full,
    output ctrl_t   ctl,
    output logic    wr_err
);

    logic matched_q;
    logic accept;
    logic flush;
    logic wr_ok;
    logic rx_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            matched_q <= 1'b0;
            wr_err    <= 1'b0;
        end else begin
            if (ev.addr_match)
                matched_q <= 1'b1;
            else if (ev.start)
                matched_q <= 1'b0;
            if (ctl.wr_bad)
                wr_err <= 1'b1;
        end
    end

    always_comb begin
        accept  = write_permitted(ev.xmit, ev.master, matched_q);
        flush   = ev.start && ev.master;
        wr_ok   = cpu_wr && accept && !flush;
        rx_done = ev.frame_done && !ev.xmit;

        ctl          = '0;
        ctl.shift_op = SH_HOLD;
        ctl.wr_bad   = cpu_wr && !accept;
        ctl.rx_load  = rx_done && (!rx_full || cpu_rd);
        ctl.rx_ovr   = rx_done && rx_full && !cpu_rd;

        if (flush) begin
            ctl.shift_op = SH_FLUSH;
            ctl.tx_flush = 1'b1;
        end else if (rx_done) begin
            ctl.shift_op = SH_FROM_BUS;
        end else if (ev.xmit) begin
            if (ev.frame_done) begin
                if (!tx_empty) begin
                    ctl.shift_op = SH_FROM_TX;
                    ctl.tx_take  = 1'b1;
                    ctl.tx_wr    = wr_ok;
                end else if (wr_ok) begin
                    ctl.shift_op = SH_FROM_CPU;
                end else begin
                    ctl.shift_op = SH_RELEASE;
                end
            end else if (wr_ok) begin
                if (!shift_busy)
                    ctl.shift_op = SH_FROM_CPU;
                else
                    ctl.tx_wr = 1'b1;
            end
        end
    end

    // R9
    slave_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !ev.master && !matched_q) |-> !ctl.tx_wr && (ctl.shift_op != SH_FROM_CPU));

endmodule

// File: rtl/i2c_dbuf_txbuf.sv
module i2c_dbuf_txbuf #(
    parameter int W = i2c_dbuf_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic         take,
    input  logic         flush,
    input  logic [W-1:0] wd,
    output logic [W-1:0] data,
    output logic         empty
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            empty <= 1'b1;
        end else if (flush) begin
            empty <= 1'b1;
        end else if (wr) begin
            data  <= wd;
            empty <= 1'b0;
        end else if (take) begin
            empty <= 1'b1;
        end
    end

    // R3
    tx_take_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> !empty);

endmodule

// File: rtl/i2c_dbuf_shift.sv
module i2c_dbuf_shift
    import i2c_dbuf_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  shift_op_e    op,
    input  logic [W-1:0] tx_byte,
    input  logic [W-1:0] cpu_byte,
    input  logic [W-1:0] bus_byte,
    output logic [W-1:0] q,
    output logic         busy
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            busy <= 1'b0;
        end else begin
            unique case (op)
                SH_FROM_TX: begin
                    q    <= tx_byte;
                    busy <= 1'b1;
                end
                SH_FROM_CPU: begin
                    q    <= cpu_byte;
                    busy <= 1'b1;
                end
                SH_FROM_BUS: begin
                    q    <= bus_byte;
                    busy <= 1'b0;
                end
                SH_RELEASE: busy <= 1'b0;
                SH_FLUSH: begin
                    q    <= '0;
                    busy <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/i2c_dbuf_rxbuf.sv
module i2c_dbuf_rxbuf #(
    parameter int W = i2c_dbuf_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         ovr,
    input  logic         rd,
    input  logic [W-1:0] byte_in,
    output logic [W-1:0] data,
    output logic         full,
    output logic         overrun
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data    <= '0;
            full    <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (load) begin
                data <= byte_in;
                full <= 1'b1;
            end else if (rd) begin
                full <= 1'b0;
            end
            if (ovr)
                overrun <= 1'b1;
        end
    end

    // R7
    rx_ovr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(load && ovr));

endmodule

// File: rtl/i2c_byte_dbuf.sv
module i2c_byte_dbuf
    import i2c_dbuf_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cpu_wr_en,
    input  logic [W-1:0] cpu_wr_data,
    input  logic         cpu_rd_en,
    output logic [W-1:0] cpu_rd_data,
    input  logic         bus_start,
    input  logic         bus_frame_done,
    input  logic         bus_addr_match,
    input  logic         bus_xmit,
    input  logic         bus_master,
    input  logic [W-1:0] bus_rx_byte,
    output logic [W-1:0] shift_q,
    output logic         shift_busy,
    output logic         tx_empty,
    output logic         rx_full,
    output logic         rx_overrun,
    output logic         wr_err
);

    bus_ev_t      ev;
    ctrl_t        ctl;
    logic [W-1:0] tx_data;

    always_comb begin
        ev.start      = bus_start;
        ev.frame_done = bus_frame_done;
        ev.addr_match = bus_addr_match;
        ev.xmit       = bus_xmit;
        ev.master     = bus_master;
    end

    i2c_dbuf_ctrl ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .cpu_wr     (cpu_wr_en),
        .cpu_rd     (cpu_rd_en),
        .tx_empty   (tx_empty),
        .shift_busy (shift_busy),
        .rx_full    (rx_full),
        .ctl        (ctl),
        .wr_err     (wr_err)
    );

    i2c_dbuf_txbuf #(.W(W)) txbuf_i (
        .clk   (clk),
        .rst   (rst),
        .wr    (ctl.tx_wr),
        .take  (ctl.tx_take),
        .flush (ctl.tx_flush),
        .wd    (cpu_wr_data),
        .data  (tx_data),
        .empty (tx_empty)
    );

    i2c_dbuf_shift #(.W(W)) shift_i (
        .clk      (clk),
        .rst      (rst),
        .op       (ctl.shift_op),
        .tx_byte  (tx_data),
        .cpu_byte (cpu_wr_data),
        .bus_byte (bus_rx_byte),
        .q        (shift_q),
        .busy     (shift_busy)
    );

    i2c_dbuf_rxbuf #(.W(W)) rxbuf_i (
        .clk     (clk),
        .rst     (rst),
        .load    (ctl.rx_load),
        .ovr     (ctl.rx_ovr),
        .rd      (cpu_rd_en),
        .byte_in (bus_rx_byte),
        .data    (cpu_rd_data),
        .full    (rx_full),
        .overrun (rx_overrun)
    );

    // R8
    master_start_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_start && bus_master) |=> (tx_empty && !shift_busy && shift_q == '0));

    // R5
    rx_mode_no_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_xmit && !bus_start) |=> !$rose(tx_empty));

    // R10
    rx_write_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr_en && !bus_xmit && !bus_start) |=> (wr_err && $stable(tx_empty)));

    // R6
    rx_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_frame_done && !bus_xmit) |=> rx_full);

    // R6
    rx_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd_en && !(bus_frame_done && !bus_xmit)) |=> !rx_full);

    // R7
    rx_overrun_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_frame_done && !bus_xmit && rx_full && !cpu_rd_en)
        |=> (rx_overrun && $stable(cpu_rd_data)));

endmodule

// File: tb/i2c_byte_dbuf_tb_top.sv
`timescale 1ns/1ps
module i2c_byte_dbuf_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_wr_en = 1'b0;
    logic [7:0] cpu_wr_data = '0;
    logic       cpu_rd_en = 1'b0;
    logic [7:0] cpu_rd_data;
    logic       bus_start = 1'b0;
    logic       bus_frame_done = 1'b0;
    logic       bus_addr_match = 1'b0;
    logic       bus_xmit = 1'b0;
    logic       bus_master = 1'b0;
    logic [7:0] bus_rx_byte = '0;
    logic [7:0] shift_q;
    logic       shift_busy;
    logic       tx_empty;
    logic       rx_full;
    logic       rx_overrun;
    logic       wr_err;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    // reference state
    logic [7:0] m_sh, m_tx, m_rx;
    logic       m_busy, m_empty, m_full, m_ovr, m_err, m_match;

    always #2.5 clk = ~clk;

    i2c_byte_dbuf dut_i (
        .clk(clk), .rst(rst),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
        .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data),
        .bus_start(bus_start), .bus_frame_done(bus_frame_done),
        .bus_addr_match(bus_addr_match), .bus_xmit(bus_xmit),
        .bus_master(bus_master), .bus_rx_byte(bus_rx_byte),
        .shift_q(shift_q), .shift_busy(shift_busy), .tx_empty(tx_empty),
        .rx_full(rx_full), .rx_overrun(rx_overrun), .wr_err(wr_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sh = '0; m_tx = '0; m_rx = '0;
        m_busy = 0; m_empty = 1; m_full = 0; m_ovr = 0; m_err = 0; m_match = 0;
    endtask

    task automatic compare_all();
        chk("R2", "shift_q",     shift_q,     m_sh);
        chk("R4", "shift_busy",  {7'd0, shift_busy}, {7'd0, m_busy});
        chk("R3", "tx_empty",    {7'd0, tx_empty},   {7'd0, m_empty});
        chk("R6", "rx_full",     {7'd0, rx_full},    {7'd0, m_full});
        chk("R6", "cpu_rd_data", cpu_rd_data, m_rx);
        chk("R7", "rx_overrun",  {7'd0, rx_overrun}, {7'd0, m_ovr});
        chk("R10", "wr_err",     {7'd0, wr_err},     {7'd0, m_err});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cpu_wr_en = 0; cpu_rd_en = 0; bus_start = 0; bus_frame_done = 0; bus_addr_match = 0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        model_reset();
    endtask

    // one cycle: drive inputs, predict, wait edge, compare
    task automatic step(input logic wr, input logic [7:0] wd, input logic rd,
                        input logic st, input logic fd, input logic am,
                        input logic xm, input logic ms, input logic [7:0] rxb);
        logic [7:0] n_sh, n_tx, n_rx;
        logic n_busy, n_empty, n_full, n_ovr, n_err, n_match, acc, wok;
        cpu_wr_en = wr; cpu_wr_data = wd; cpu_rd_en = rd;
        bus_start = st; bus_frame_done = fd; bus_addr_match = am;
        bus_xmit = xm; bus_master = ms; bus_rx_byte = rxb;

        n_sh = m_sh; n_tx = m_tx; n_rx = m_rx; n_busy = m_busy; n_empty = m_empty;
        n_full = m_full; n_ovr = m_ovr; n_err = m_err; n_match = m_match;
        acc = xm && (ms || m_match);
        if (wr && !acc) n_err = 1;
        if (am) n_match = 1; else if (st) n_match = 0;
        // receive side
        if (fd && !xm) begin
            if (m_full && !rd) n_ovr = 1;
            else begin n_rx = rxb; n_full = 1; end
        end else if (rd) n_full = 0;
        // transmit side and shift register
        if (st && ms) begin
            n_sh = 0; n_busy = 0; n_empty = 1;
        end else if (fd && !xm) begin
            n_sh = rxb; n_busy = 0;
        end else if (xm) begin
            wok = wr && acc;
            if (fd) begin
                if (!m_empty) begin
                    n_sh = m_tx; n_busy = 1; n_empty = 1;
                    if (wok) begin n_tx = wd; n_empty = 0; end
                end else if (wok) begin
                    n_sh = wd; n_busy = 1;
                end else n_busy = 0;
            end else if (wok) begin
                if (!m_busy) begin n_sh = wd; n_busy = 1; end
                else begin n_tx = wd; n_empty = 0; end
            end
        end

        @(posedge clk);
        #1;
        m_sh = n_sh; m_tx = n_tx; m_rx = n_rx; m_busy = n_busy; m_empty = n_empty;
        m_full = n_full; m_ovr = n_ovr; m_err = n_err; m_match = n_match;
        compare_all();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        logic xm_r, ms_r;
        model_reset();
        do_reset();
        // R1 reset state
        chk("R1", "tx_empty", {7'd0, tx_empty}, 8'd1);
        chk("R1", "shift_busy", {7'd0, shift_busy}, 8'd0);
        chk("R1", "rx_full", {7'd0, rx_full}, 8'd0);
        chk("R1", "flags", {6'd0, rx_overrun, wr_err}, 8'd0);
        chk("R1", "shift_q", shift_q, 8'h00);
        chk("R1", "cpu_rd_data", cpu_rd_data, 8'h00);

        // master transmit: R2 direct load
        step(1, 8'hA5, 0, 0, 0, 0, 1, 1, 8'h00);
        chk("R2", "direct load", shift_q, 8'hA5);
        chk("R2", "empty kept", {7'd0, tx_empty}, 8'd1);
        // R3 second write buffered, then moved on frame done
        step(1, 8'h3C, 0, 0, 0, 0, 1, 1, 8'h00);
        chk("R3", "buffered clears empty", {7'd0, tx_empty}, 8'd0);
        chk("R3", "shift unchanged", shift_q, 8'hA5);
        step(0, 8'h00, 0, 0, 1, 0, 1, 1, 8'h00);
        chk("R3", "moved to shift", shift_q, 8'h3C);
        chk("R3", "empty set", {7'd0, tx_empty}, 8'd1);
        // R4 frame done with nothing pending frees shift
        step(0, 8'h00, 0, 0, 1, 0, 1, 1, 8'h00);
        chk("R4", "released", {7'd0, shift_busy}, 8'd0);
        chk("R4", "data kept", shift_q, 8'h3C);
        // R4 write colliding with frame done is forwarded
        step(1, 8'h11, 0, 0, 0, 0, 1, 1, 8'h00);
        step(1, 8'h22, 0, 0, 1, 0, 1, 1, 8'h00);
        chk("R4", "forward on collision", shift_q, 8'h22);
        chk("R4", "busy", {7'd0, shift_busy}, 8'd1);
        chk("R4", "empty", {7'd0, tx_empty}, 8'd1);
        // R8 master start discards pending data and same-cycle write
        step(1, 8'h77, 0, 0, 0, 0, 1, 1, 8'h00);
        step(1, 8'h99, 0, 1, 0, 0, 1, 1, 8'h00);
        chk("R8", "flush empty", {7'd0, tx_empty}, 8'd1);
        chk("R8", "flush busy", {7'd0, shift_busy}, 8'd0);
        chk("R8", "flush data", shift_q, 8'h00);
        chk("R8", "no error", {7'd0, wr_err}, 8'd0);

        // receive mode
        step(1, 8'h44, 0, 0, 0, 0, 0, 1, 8'h00);
        chk("R10", "write refused", {7'd0, wr_err}, 8'd1);
        chk("R10", "shift untouched", shift_q, 8'h00);
        chk("R10", "empty untouched", {7'd0, tx_empty}, 8'd1);
        step(0, 8'h00, 0, 0, 1, 0, 0, 1, 8'h5A);
        chk("R6", "rx loaded", cpu_rd_data, 8'h5A);
        chk("R6", "full set", {7'd0, rx_full}, 8'd1);
        chk("R5", "shift from bus", shift_q, 8'h5A);
        step(0, 8'h00, 0, 0, 1, 0, 0, 1, 8'h66);
        chk("R7", "old byte kept", cpu_rd_data, 8'h5A);
        chk("R7", "overrun", {7'd0, rx_overrun}, 8'd1);
        step(0, 8'h00, 1, 0, 1, 0, 0, 1, 8'h77);
        chk("R11", "read+load", cpu_rd_data, 8'h77);
        chk("R11", "full stays", {7'd0, rx_full}, 8'd1);
        step(0, 8'h00, 1, 0, 0, 0, 0, 1, 8'h00);
        chk("R6", "read clears", {7'd0, rx_full}, 8'd0);
        chk("R10", "err sticky", {7'd0, wr_err}, 8'd1);

        // R5 pending transmit byte survives receive-mode frames
        do_reset();
        step(1, 8'hC1, 0, 0, 0, 0, 1, 1, 8'h00);
        step(1, 8'hC2, 0, 0, 0, 0, 1, 1, 8'h00);
        step(0, 8'h00, 0, 0, 1, 0, 0, 1, 8'hE0);
        chk("R5", "no take in rx", {7'd0, tx_empty}, 8'd0);
        step(0, 8'h00, 0, 0, 1, 0, 1, 1, 8'h00);
        chk("R5", "held byte moves later", shift_q, 8'hC2);

        // R9 slave acceptance
        do_reset();
        step(1, 8'h55, 0, 0, 0, 0, 1, 0, 8'h00);
        chk("R9", "before match refused", {7'd0, shift_busy}, 8'd0);
        chk("R9", "error set", {7'd0, wr_err}, 8'd1);
        do_reset();
        step(0, 8'h00, 0, 0, 0, 1, 1, 0, 8'h00);
        step(1, 8'h56, 0, 0, 0, 0, 1, 0, 8'h00);
        chk("R9", "after match accepted", shift_q, 8'h56);
        chk("R9", "no error", {7'd0, wr_err}, 8'd0);
        step(0, 8'h00, 0, 1, 1, 0, 1, 0, 8'h00);
        step(1, 8'h57, 0, 0, 0, 0, 1, 0, 8'h00);
        chk("R9", "start forgets match", {7'd0, wr_err}, 8'd1);
        chk("R9", "refused data", {7'd0, shift_busy}, 8'd0);

        // constrained random against reference
        do_reset();
        seed_dummy = $urandom(32'd20240611);
        xm_r = 1; ms_r = 1;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 40 == 0) xm_r = ~xm_r;
            if ($urandom % 90 == 0) ms_r = ~ms_r;
            step(($urandom % 4) == 0, 8'($urandom), ($urandom % 5) == 0,
                 ($urandom % 29) == 0, ($urandom % 4) == 0, ($urandom % 13) == 0,
                 xm_r, ms_r, 8'($urandom));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule